// File: doc/BRIEF.md
# Indexed Step-Table Sequencer

This block replays hardware-state records from a preloaded table under the control of a small instruction stream. A record sets the tone frequency, the amplitude, the phase and an 8-bit TTL mask, and says how long these values stay on the outputs. Instructions never carry those values. They name a record by its table index, open a counted loop, close a loop, or halt. A waveform that repeats N times therefore needs only its distinct records plus two loop instructions.

A host fills the record table and the program memory through a single write port while the block is idle. It then pulses `start`. From that point the block runs on its own until the halt instruction retires. It then drops `busy` and pulses `done`. One duration unit is one clock period, which is 4 ns at 250 MHz. A fetch engine decodes one instruction per cycle and runs ahead of playback through a one-entry buffer. This hides loop bookkeeping behind the time that each record is held.

Top module: `step_sequencer`

## Requirements
- R1: While reset is high and after it is released, `busy` and `done` are 0 and `tone_freq`, `tone_amp`, `tone_phase` and `ttl_out` are 0.
- R2: A host word written to the table is packed {freq[85:54], amp[53:40], phase[39:24], ttl[23:16], dur[15:0]}. A program word is {op[17:16], arg[15:0]}, where op 0 plays the record at index arg modulo the table depth. The first played record appears on all four outputs together, on the second clock edge after the edge that samples `start`.
- R3: A played record holds for D = dur cycles. If k loop instructions are decoded between it and the next play or halt, it holds for max(D, k+1) cycles. There are no idle cycles between records.
- R4: A record with duration 0 holds for exactly one cycle, the same as duration 1.
- R5: Op 1 opens a loop with pass count arg, where 0 is treated as 1. Op 2 closes the innermost loop. It jumps back to the first body instruction while passes remain, so a body of M plays repeated N times yields M×N steps drawn from M records.
- R6: Loops nest up to 4 deep, and each level keeps its own pass count.
- R7: Op 3 halts. `busy` falls and `done` is high for exactly one cycle at the edge where the last record's hold ends, computed as in R3 with the halt taking the place of the next play. After that the outputs keep the last record.
- R8: While `busy` is high, host writes to either memory and further `start` pulses have no effect. `host_wr_prog` = 1 selects the program memory and 0 selects the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 250 MHz nominal |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_prog | input | 1 | 1 writes the program memory, 0 writes the record table |
| host_wr_addr | input | 5 | Entry address for the host write |
| host_wr_data | input | 86 | Record or instruction word (instructions use bits 17:0) |
| start | input | 1 | Begin playback at instruction 0 |
| busy | output | 1 | High from the edge after `start` until the run ends |
| done | output | 1 | One-cycle pulse at the end of a run |
| tone_freq | output | 32 | Tone frequency of the current record |
| tone_amp | output | 14 | Tone amplitude of the current record |
| tone_phase | output | 16 | Tone phase of the current record |
| ttl_out | output | 8 | TTL output mask of the current record |

## Verification
The hardest case to reach from the ports is the fetch engine falling behind playback. This happens when a short record is followed by a chain of loop closes and opens that takes longer to decode than the record is held, so the record must stretch without any gap or duplicated step. The stimulus reaches it in two ways. Directed programs pair one-cycle records with four-deep loop nests. Seeded random programs mix durations of 0 to 5 with random nesting, and a bench model derives every expected step start cycle from the max(D, k+1) rule. Writes and `start` pulses are also injected in the middle of each longer run to show that busy-time traffic is ignored.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int FREQ_W  = 32;
    localparam int AMP_W   = 14;
    localparam int PHASE_W = 16;
    localparam int TTL_W   = 8;
    localparam int DUR_W   = 16;
    localparam int CNT_W   = 16;
    localparam int OP_W    = 2;

    localparam int INSTR_W = OP_W + CNT_W;
    localparam int REC_W   = FREQ_W + AMP_W + PHASE_W + TTL_W + DUR_W;

    typedef enum logic [OP_W-1:0] {
        OP_PLAY = 2'd0,
        OP_LOOP = 2'd1,
        OP_NEXT = 2'd2,
        OP_HALT = 2'd3
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [CNT_W-1:0] arg;
    } instr_t;

    typedef struct packed {
        logic [FREQ_W-1:0]  freq;
        logic [AMP_W-1:0]   amp;
        logic [PHASE_W-1:0] phase;
        logic [TTL_W-1:0]   ttl;
        logic [DUR_W-1:0]   dur;
    } step_rec_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_e;

    // A zero duration still occupies one cycle
    function automatic logic [DUR_W-1:0] hold_cycles(input logic [DUR_W-1:0] d);
        return (d == '0) ? DUR_W'(1) : d;
    endfunction

    // A zero pass count still runs the body once
    function automatic logic [CNT_W-1:0] pass_count(input logic [CNT_W-1:0] n);
        return (n == '0) ? CNT_W'(1) : n;
    endfunction

endpackage

// File: rtl/seq_mem.sv
module seq_mem #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/seq_loop_stack.sv
module seq_loop_stack
    import seq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PC_W  = 5,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int SP_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             push,
    input  logic [PC_W-1:0]  push_start,
    input  logic [CNT_W-1:0] push_count,
    input  logic             dec,
    input  logic             pop,
    output logic [PC_W-1:0]  top_start,
    output logic [CNT_W-1:0] top_count,
    output logic             empty,
    output logic             full
);

    logic [PC_W-1:0]  start_q [DEPTH];
    logic [CNT_W-1:0] cnt_q   [DEPTH];
    logic [SP_W-1:0]  sp_q;
    logic [IDX_W-1:0] wr_i, rd_i;

    assign empty = (sp_q == '0);
    assign full  = (sp_q == SP_W'(DEPTH));
    assign wr_i  = IDX_W'(sp_q);
    assign rd_i  = empty ? '0 : IDX_W'(sp_q - SP_W'(1));

    assign top_start = start_q[rd_i];
    assign top_count = cnt_q[rd_i];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sp_q <= '0;
        end else if (push && !full) begin
            start_q[wr_i] <= push_start;
            cnt_q[wr_i]   <= pass_count(push_count);
            sp_q          <= sp_q + SP_W'(1);
        end else if (pop && !empty) begin
            sp_q <= sp_q - SP_W'(1);
        end else if (dec && !empty) begin
            cnt_q[rd_i] <= cnt_q[rd_i] - CNT_W'(1);
        end
    end

    // R6: an opened level becomes the top with its own pass count
    a_r6_push_top: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !clear) |=> (!empty && top_count == pass_count($past(push_count))));

endmodule

// File: rtl/seq_player.sv
module seq_player
    import seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  step_rec_t          rec,
    output logic               step_last,
    output logic [FREQ_W-1:0]  freq,
    output logic [AMP_W-1:0]   amp,
    output logic [PHASE_W-1:0] phase,
    output logic [TTL_W-1:0]   ttl
);

    logic [DUR_W-1:0] timer_q;

    // Current hold ends at the coming edge (or nothing is playing)
    assign step_last = (timer_q <= DUR_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            timer_q <= '0;
            freq    <= '0;
            amp     <= '0;
            phase   <= '0;
            ttl     <= '0;
        end else if (load) begin
            timer_q <= hold_cycles(rec.dur);
            freq    <= rec.freq;
            amp     <= rec.amp;
            phase   <= rec.phase;
            ttl     <= rec.ttl;
        end else if (timer_q != '0) begin
            timer_q <= timer_q - DUR_W'(1);
        end
    end

    // R3: outputs are frozen while a hold has cycles left
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (timer_q > DUR_W'(1)) |=> ($stable(freq) && $stable(amp) && $stable(phase) && $stable(ttl)));

    // R4: a zero-length record leaves exactly one cycle
    a_r4_zero_dur: assert property (@(posedge clk) disable iff (rst)
        (load && rec.dur == '0) |=> (timer_q == DUR_W'(1)));

endmodule

// File: rtl/step_sequencer.sv
module step_sequencer
    import seq_pkg::*;
#(
    parameter int TBL_DEPTH  = 16,
    parameter int PROG_DEPTH = 32,
    parameter int LOOP_DEPTH = 4,
    localparam int TIDX_W = $clog2(TBL_DEPTH),
    localparam int PC_W   = $clog2(PROG_DEPTH),
    localparam int ADDR_W = (TIDX_W > PC_W) ? TIDX_W : PC_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr_en,
    input  logic               host_wr_prog,
    input  logic [ADDR_W-1:0]  host_wr_addr,
    input  logic [REC_W-1:0]   host_wr_data,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic [FREQ_W-1:0]  tone_freq,
    output logic [AMP_W-1:0]   tone_amp,
    output logic [PHASE_W-1:0] tone_phase,
    output logic [TTL_W-1:0]   ttl_out
);

    run_e             state_q;
    logic [PC_W-1:0]  pc_q;
    logic             halted_q, pend_q, done_q;
    logic [CNT_W-1:0] pend_arg_q;

    logic [INSTR_W-1:0] prog_rdata;
    logic [REC_W-1:0]   tbl_rdata;
    instr_t             instr;
    step_rec_t          rec_rd;

    logic running, go, step_last, consume, accept, finish;
    logic tbl_we, prog_we;
    logic push, dec, pop, loop_back;
    logic [PC_W-1:0]  top_start;
    logic [CNT_W-1:0] top_count;
    logic stk_empty, stk_full;
    logic [TIDX_W-1:0] tbl_waddr, tbl_raddr;
    logic [PC_W-1:0]   prog_waddr;

    assign running = (state_q == ST_RUN);
    assign busy    = running;
    assign done    = done_q;
    assign go      = !running && start;

    // Host port is closed for the whole run
    assign tbl_we     = host_wr_en && !host_wr_prog && !running;
    assign prog_we    = host_wr_en &&  host_wr_prog && !running;
    assign tbl_waddr  = TIDX_W'(32'(host_wr_addr) % TBL_DEPTH);
    assign prog_waddr = PC_W'(32'(host_wr_addr) % PROG_DEPTH);
    assign tbl_raddr  = TIDX_W'(32'(pend_arg_q) % TBL_DEPTH);

    seq_mem #(.WIDTH(REC_W), .DEPTH(TBL_DEPTH)) u_table (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_waddr),
        .wdata (host_wr_data),
        .raddr (tbl_raddr),
        .rdata (tbl_rdata)
    );

    seq_mem #(.WIDTH(INSTR_W), .DEPTH(PROG_DEPTH)) u_prog (
        .clk   (clk),
        .we    (prog_we),
        .waddr (prog_waddr),
        .wdata (host_wr_data[INSTR_W-1:0]),
        .raddr (pc_q),
        .rdata (prog_rdata)
    );

    assign instr  = instr_t'(prog_rdata);
    assign rec_rd = step_rec_t'(tbl_rdata);

    // Buffer handoff: player takes the pending record as its hold ends,
    // and the engine decodes whenever the buffer is free or freeing.
    assign consume = running && step_last && pend_q;
    assign accept  = running && !halted_q && (!pend_q || consume);
    assign finish  = running && halted_q && !pend_q && step_last;

    assign loop_back = !stk_empty && (top_count > CNT_W'(1));
    assign push = accept && (instr.op == OP_LOOP) && !stk_full;
    assign dec  = accept && (instr.op == OP_NEXT) && loop_back;
    assign pop  = accept && (instr.op == OP_NEXT) && !stk_empty && !loop_back;

    seq_loop_stack #(.DEPTH(LOOP_DEPTH), .PC_W(PC_W)) u_loops (
        .clk        (clk),
        .rst        (rst),
        .clear      (go),
        .push       (push),
        .push_start (pc_q + PC_W'(1)),
        .push_count (instr.arg),
        .dec        (dec),
        .pop        (pop),
        .top_start  (top_start),
        .top_count  (top_count),
        .empty      (stk_empty),
        .full       (stk_full)
    );

    seq_player u_player (
        .clk       (clk),
        .rst       (rst),
        .load      (consume),
        .rec       (rec_rd),
        .step_last (step_last),
        .freq      (tone_freq),
        .amp       (tone_amp),
        .phase     (tone_phase),
        .ttl       (ttl_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            pc_q       <= '0;
            halted_q   <= 1'b0;
            pend_q     <= 1'b0;
            pend_arg_q <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= finish;
            if (go) begin
                state_q  <= ST_RUN;
                pc_q     <= '0;
                halted_q <= 1'b0;
                pend_q   <= 1'b0;
            end else if (running) begin
                if (finish) begin
                    state_q <= ST_IDLE;
                end
                if (accept) begin
                    unique case (instr.op)
                        OP_PLAY: begin
                            pend_arg_q <= instr.arg;
                            pc_q       <= pc_q + PC_W'(1);
                        end
                        OP_LOOP: pc_q <= pc_q + PC_W'(1);
                        OP_NEXT: pc_q <= loop_back ? top_start : pc_q + PC_W'(1);
                        OP_HALT: halted_q <= 1'b1;
                    endcase
                end
                if (accept && instr.op == OP_PLAY) begin
                    pend_q <= 1'b1;
                end else if (consume) begin
                    pend_q <= 1'b0;
                end
            end
        end
    end

    // R5: a loop close with passes left returns to the body start
    a_r5_backedge: assert property (@(posedge clk) disable iff (rst)
        (accept && instr.op == OP_NEXT && !stk_empty && top_count > CNT_W'(1))
        |=> (pc_q == $past(top_start)));

    // R7: completion is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: busy only ever drops together with done
    a_r7_busy_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R8: outside a run the outputs never move
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(ttl_out) && $stable(tone_freq) && $stable(tone_amp) && $stable(tone_phase)));

endmodule

// File: tb/sim_step_sequencer.sv
`timescale 1ns/1ps
module sim_step_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr_en = 1'b0;
    logic        host_wr_prog = 1'b0;
    logic [4:0]  host_wr_addr = '0;
    logic [85:0] host_wr_data = '0;
    logic        start = 1'b0;
    logic        busy, done;
    logic [31:0] tone_freq;
    logic [13:0] tone_amp;
    logic [15:0] tone_phase;
    logic [7:0]  ttl_out;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    step_sequencer u0 (
        .clk(clk), .rst(rst),
        .host_wr_en(host_wr_en), .host_wr_prog(host_wr_prog),
        .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
        .start(start), .busy(busy), .done(done),
        .tone_freq(tone_freq), .tone_amp(tone_amp),
        .tone_phase(tone_phase), .ttl_out(ttl_out)
    );

    // Bench copies of memory contents
    logic [17:0] prog_m [32];
    logic [85:0] tbl_m  [16];

    // Expected step list: start cycle and output image {freq,amp,phase,ttl}
    int          st_start [4096];
    logic [69:0] st_out   [4096];
    int          nsteps;
    int          end_cyc;
    logic [69:0] prev_out = '0;

    function automatic logic [17:0] i_play(input int idx); return {2'd0, 16'(idx)}; endfunction
    function automatic logic [17:0] i_loop(input int n);   return {2'd1, 16'(n)};   endfunction
    function automatic logic [17:0] i_next();              return {2'd2, 16'd0};    endfunction
    function automatic logic [17:0] i_halt();              return {2'd3, 16'd0};    endfunction

    function automatic logic [85:0] mk_rec(input int dur);
        return {$urandom(), 14'($urandom()), 16'($urandom()), 8'($urandom()), 16'(dur)};
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Cycle model: each step holds max(D, k+1), k = loop ops decoded before the next play/halt
    task automatic build_model();
        int pc, k, s, d, sp, guard, op, arg, idx, nxt;
        int ls_start [4];
        int ls_cnt   [4];
        pc = 0; k = 0; s = 1; d = 1; sp = 0; guard = 0;
        nsteps = 1; st_start[0] = 0; st_out[0] = prev_out;
        end_cyc = -1;
        while (end_cyc < 0 && guard < 100000 && nsteps < 4096) begin
            guard++;
            op  = int'(prog_m[pc][17:16]);
            arg = int'(prog_m[pc][15:0]);
            case (op)
                0: begin
                    nxt = s + imax(d, k + 1);
                    idx = arg % 16;
                    st_start[nsteps] = nxt;
                    st_out[nsteps]   = tbl_m[idx][85:16];
                    nsteps++;
                    s = nxt;
                    d = (tbl_m[idx][15:0] == 16'd0) ? 1 : int'(tbl_m[idx][15:0]);
                    k = 0;
                    pc = (pc + 1) % 32;
                end
                1: begin
                    if (sp < 4) begin
                        ls_start[sp] = (pc + 1) % 32;
                        ls_cnt[sp]   = (arg == 0) ? 1 : arg;
                        sp++;
                    end
                    k++;
                    pc = (pc + 1) % 32;
                end
                2: begin
                    if (sp > 0 && ls_cnt[sp-1] > 1) begin
                        ls_cnt[sp-1]--;
                        pc = ls_start[sp-1];
                    end else begin
                        if (sp > 0) sp--;
                        pc = (pc + 1) % 32;
                    end
                    k++;
                end
                default: end_cyc = s + imax(d, k + 1);
            endcase
        end
        prev_out = st_out[nsteps-1];
    endtask

    task automatic load_all();
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            host_wr_en = 1'b1; host_wr_prog = 1'b1;
            host_wr_addr = 5'(i); host_wr_data = 86'(prog_m[i]);
        end
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            host_wr_en = 1'b1; host_wr_prog = 1'b0;
            host_wr_addr = 5'(i); host_wr_data = tbl_m[i];
        end
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic run_prog(input string tag);
        int ptr;
        logic [69:0] obs;
        build_model();
        load_all();
        @(negedge clk);
        start = 1'b1;
        ptr = 0;
        for (int j = 0; j <= end_cyc + 1; j++) begin
            @(negedge clk);
            if (j == 0) start = 1'b0;
            while (ptr + 1 < nsteps && st_start[ptr+1] <= j) ptr++;
            obs = {tone_freq, tone_amp, tone_phase, ttl_out};
            chk(obs == st_out[ptr], tag, $sformatf("outputs cycle %0d", j), 128'(obs), 128'(st_out[ptr]));
            chk(busy == (j < end_cyc), "R7", $sformatf("busy cycle %0d", j), 128'(busy), 128'(j < end_cyc));
            chk(done == (j == end_cyc), "R7", $sformatf("done cycle %0d", j), 128'(done), 128'(j == end_cyc));
            // R8: traffic injected mid-run must leave both memories untouched
            if (end_cyc > 8) begin
                if (j == 3) begin
                    host_wr_en = 1'b1; host_wr_prog = 1'($urandom());
                    host_wr_addr = 5'($urandom());
                    host_wr_data = {$urandom(), $urandom(), 22'($urandom())};
                end
                if (j == 4) host_wr_en = 1'b0;
                if (j == 5) start = 1'b1;
                if (j == 6) start = 1'b0;
            end
        end
    endtask

    task automatic fill_halt();
        for (int i = 0; i < 32; i++) prog_m[i] = i_halt();
    endtask

    task automatic gen_random();
        int n, depth, r;
        fill_halt();
        for (int i = 0; i < 16; i++) tbl_m[i] = mk_rec($urandom_range(0, 5));
        n = 0; depth = 0;
        while (n < 24) begin
            r = $urandom_range(0, 9);
            if (r < 5) prog_m[n] = i_play($urandom_range(0, 15));
            else if (r < 7 && depth < 3 && n < 20) begin
                prog_m[n] = i_loop($urandom_range(1, 3)); depth++;
            end else if (depth > 0) begin
                prog_m[n] = i_next(); depth--;
            end else prog_m[n] = i_play($urandom_range(0, 15));
            n++;
        end
        while (depth > 0) begin prog_m[n] = i_next(); depth--; n++; end
        prog_m[n] = i_halt();
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy in reset", 128'(busy), 128'(0));
        chk(done == 1'b0, "R1", "done in reset", 128'(done), 128'(0));
        chk({tone_freq, tone_amp, tone_phase, ttl_out} == 70'd0, "R1", "outputs in reset",
            128'({tone_freq, tone_amp, tone_phase, ttl_out}), 128'(0));
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1", "idle after reset", 128'({busy, done}), 128'(0));
        chk(ttl_out == 8'd0, "R1", "ttl after reset", 128'(ttl_out), 128'(0));

        for (int i = 0; i < 16; i++) tbl_m[i] = mk_rec(i % 4 + 1);

        // R2: single play, timing of first record
        fill_halt();
        tbl_m[5] = mk_rec(3);
        prog_m[0] = i_play(5);
        run_prog("R2");

        // R2: index taken modulo table depth
        fill_halt();
        prog_m[0] = i_play(16 + 7); prog_m[1] = i_play(2);
        run_prog("R2");

        // R4: zero duration record
        fill_halt();
        tbl_m[1] = mk_rec(0); tbl_m[2] = mk_rec(2);
        prog_m[0] = i_play(1); prog_m[1] = i_play(2); prog_m[2] = i_play(1); prog_m[3] = i_play(1);
        run_prog("R4");

        // R5: pass counts 1, 0 and 3, reusing the same records
        fill_halt();
        tbl_m[3] = mk_rec(4); tbl_m[4] = mk_rec(5); tbl_m[6] = mk_rec(6);
        prog_m[0] = i_loop(1); prog_m[1] = i_play(3); prog_m[2] = i_play(4); prog_m[3] = i_next();
        prog_m[4] = i_loop(0); prog_m[5] = i_play(6); prog_m[6] = i_next();
        prog_m[7] = i_loop(3); prog_m[8] = i_play(3); prog_m[9] = i_play(4); prog_m[10] = i_next();
        run_prog("R5");

        // R6: four nested levels with distinct counts and plays at each level
        fill_halt();
        tbl_m[8] = mk_rec(7); tbl_m[9] = mk_rec(2); tbl_m[10] = mk_rec(1); tbl_m[11] = mk_rec(3);
        prog_m[0] = i_loop(2); prog_m[1] = i_play(8);
        prog_m[2] = i_loop(3); prog_m[3] = i_play(9);
        prog_m[4] = i_loop(2); prog_m[5] = i_play(10);
        prog_m[6] = i_loop(2); prog_m[7] = i_play(11);
        prog_m[8] = i_next(); prog_m[9] = i_next(); prog_m[10] = i_next(); prog_m[11] = i_next();
        prog_m[12] = i_play(9);
        run_prog("R6");

        // R3: one-cycle records behind chains of loop ops (stretch) and long ones (no stretch)
        fill_halt();
        tbl_m[12] = mk_rec(1); tbl_m[13] = mk_rec(9);
        prog_m[0] = i_loop(2); prog_m[1] = i_loop(2); prog_m[2] = i_play(12);
        prog_m[3] = i_next(); prog_m[4] = i_play(13); prog_m[5] = i_next();
        prog_m[6] = i_play(12); prog_m[7] = i_play(12);
        run_prog("R3");

        // R7: halt only
        fill_halt();
        run_prog("R7");

        // R3/R8: seeded random programs with mid-run host traffic
        for (int t = 0; t < 10; t++) begin
            gen_random();
            run_prog("R3 R8 random");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule